// File: doc/BRIEF.md
# Rate-Detect Completion Sequencer

This block belongs to one channel of a multi-rate serial link. It controls the datapath while an automatic line-rate search runs, and after that search succeeds. When the search logic reports success with a rate-found pulse, the block does the following:

- It captures the detected rate code as status.
- It fires reset pulses into the transmit FIFO and the receive FIFO.
- It releases the receive output clock enable.
- It decides when the transmit path stops sending idle/test pattern and starts serializing parallel input data.

Software can ask that transmit switchover wait for it. To do so, it sets the manual gate bit together with the transmit-override bit. The block then waits after lock until software writes a manual transmit FIFO reset. This gives software time to read the detected rate and set up the rest of the system first. A new search start, or a loss of channel synchronization, returns the block to searching.

Top module: `rate_lock_seq`

## Requirements
- R1: After reset, every output is 0. The block is in the searching state.
- R2: rateFound while searching produces a one-cycle pulse on both txFifoRst and rxFifoRst in the following cycle. The gate setting has no effect on this.
- R3: rateStatus and rateValid update in the same cycle as the R2 pulses. rateStatus takes the rateCode value sampled with rateFound, and rateValid goes to 1. While rateValid is 0, rateStatus reads 0.
- R4: The manual gate is effective only when both txOverride and manualGate are 1 in the cycle rateFound is accepted. Any other combination behaves as gate off.
- R5: With the gate off, txSelParallel goes to 1 one cycle after the automatic reset pulse.
- R6: With the gate on, txSelParallel stays 0 and waitRecenter reads 1 after lock. This holds until txFifoRstWr is seen. That write gives a txFifoRst pulse in the next cycle, and txSelParallel goes to 1 one cycle after that pulse. waitRecenter goes to 0 in the same cycle as that pulse.
- R7: While searching, rxClkEn follows rxClkFree with one cycle of delay. From the cycle of the R2 pulses, rxClkEn is 1 whether or not the gate is on.
- R8: txFifoRstWr in any state produces a txFifoRst pulse one cycle later. While searching, it produces no rxFifoRst pulse and does not select parallel data.
- R9: searchStart or syncLost takes effect one cycle later. It clears txSelParallel, rateValid, rateStatus and waitRecenter, and it wins over a rateFound in the same cycle.
- R10: rateFound while not searching is ignored. It produces no rxFifoRst pulse and does not change the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| searchStart | input | 1 | A new rate search begins |
| syncLost | input | 1 | Channel synchronization lost |
| rateFound | input | 1 | Rate search success pulse |
| rateCode | input | RATE_W | Detected rate code, valid with rateFound |
| txOverride | input | 1 | Transmit-datapath override control bit |
| manualGate | input | 1 | Hold transmit switchover for software |
| rxClkFree | input | 1 | 1: receive clock runs during search |
| txFifoRstWr | input | 1 | Software write of manual transmit FIFO reset |
| txFifoRst | output | 1 | Transmit FIFO reset pulse |
| rxFifoRst | output | 1 | Receive FIFO reset pulse |
| txSelParallel | output | 1 | 1: serialize parallel data, 0: idle/test pattern |
| rxClkEn | output | 1 | Receive output clock enable |
| rateValid | output | 1 | Detected rate status is valid |
| rateStatus | output | RATE_W | Detected rate code |
| waitRecenter | output | 1 | Locked, waiting for manual recenter |

## Verification
The assertions assume that all control inputs are synchronous to clk and held steady between edges. They also assume rateCode is meaningful only in the cycle rateFound is high.

The bench drives every input on the falling edge. It pulses the strobes for exactly one cycle and keeps the control bits stable across each lock event.

Strobes that collide are applied on purpose, only in the combinations the requirements define:
- rateFound together with an abort;
- rateFound during the hold;
- a manual write during search.

// File: rtl/rls_pkg.sv
package rls_pkg;
  typedef enum logic [1:0] {
    SEQ_SEARCH = 2'd0,
    SEQ_HELD   = 2'd1,
    SEQ_LIVE   = 2'd2
  } seqState_t;

  typedef struct packed {
    logic lock;       // accepted rate success this cycle
    logic recenter;   // accepted manual recenter while held
    logic abort;      // search restart or sync loss
    logic txRstReq;   // transmit FIFO reset request
    logic live;       // parallel data path may be selected
    logic searching;  // currently in search
  } seqStrobe_t;
endpackage

// File: rtl/rls_ctrl.sv
module rls_ctrl
  import rls_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       searchStart,
  input  logic       syncLost,
  input  logic       rateFound,
  input  logic       txOverride,
  input  logic       manualGate,
  input  logic       txFifoRstWr,
  output seqStrobe_t strobes,
  output logic       waitRecenter
);
  seqState_t state, stateNxt;
  logic abortNow, lockNow, recenterNow, gateOn;

  assign abortNow    = searchStart | syncLost;
  assign gateOn      = txOverride & manualGate;
  assign lockNow     = ~abortNow & (state == SEQ_SEARCH) & rateFound;
  assign recenterNow = ~abortNow & (state == SEQ_HELD) & txFifoRstWr;

  always_comb begin
    stateNxt = state;
    if (abortNow)
      stateNxt = SEQ_SEARCH;
    else begin
      unique case (state)
        SEQ_SEARCH: if (lockNow) stateNxt = gateOn ? SEQ_HELD : SEQ_LIVE;
        SEQ_HELD:   if (recenterNow) stateNxt = SEQ_LIVE;
        SEQ_LIVE:   stateNxt = SEQ_LIVE;
        default:    stateNxt = SEQ_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_SEARCH;
    else       state <= stateNxt;
  end

  always_comb begin
    strobes.lock      = lockNow;
    strobes.recenter  = recenterNow;
    strobes.abort     = abortNow;
    strobes.txRstReq  = txFifoRstWr | lockNow;
    strobes.live      = (state == SEQ_LIVE);
    strobes.searching = (state == SEQ_SEARCH);
  end

  assign waitRecenter = (state == SEQ_HELD);

  // R9: abort, lock and recenter never coincide
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.lock, strobes.recenter, strobes.abort}));

  // R6: leaving the hold without abort requires a recenter write
  a_r6_hold_exit: assert property (@(posedge clk) disable iff (!rstN)
    (waitRecenter && !abortNow && !txFifoRstWr) |=> waitRecenter);
endmodule

// File: rtl/rls_dpath.sv
module rls_dpath
  import rls_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobes,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              rxClkFree,
  output logic              txFifoRst,
  output logic              rxFifoRst,
  output logic              txSelParallel,
  output logic              rxClkEn,
  output logic              rateValid,
  output logic [RATE_W-1:0] rateStatus
);
  localparam logic [RATE_W-1:0] RATE_NONE = '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txFifoRst     <= 1'b0;
      rxFifoRst     <= 1'b0;
      txSelParallel <= 1'b0;
      rxClkEn       <= 1'b0;
      rateValid     <= 1'b0;
      rateStatus    <= RATE_NONE;
    end else begin
      txFifoRst <= strobes.txRstReq;
      rxFifoRst <= strobes.lock;
      if (strobes.abort) begin
        txSelParallel <= 1'b0;
        rateValid     <= 1'b0;
        rateStatus    <= RATE_NONE;
        rxClkEn       <= rxClkFree;
      end else begin
        txSelParallel <= strobes.live;
        if (strobes.lock) begin
          rateValid  <= 1'b1;
          rateStatus <= rateCode;
          rxClkEn    <= 1'b1;
        end else if (strobes.searching) begin
          rxClkEn <= rxClkFree;
        end
      end
    end
  end

  // R2: receive reset only alongside transmit reset
  a_r2_rx_with_tx: assert property (@(posedge clk) disable iff (!rstN)
    rxFifoRst |-> txFifoRst);
  // R2: receive reset is a single-cycle pulse
  a_r2_rx_single: assert property (@(posedge clk) disable iff (!rstN)
    rxFifoRst |=> !rxFifoRst);
  // R5/R6: parallel select only follows a transmit reset
  a_r5_sel_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txSelParallel) |-> $past(txFifoRst));
  // R7: clock enable open whenever the rate is valid
  a_r7_valid_clk: assert property (@(posedge clk) disable iff (!rstN)
    rateValid |-> rxClkEn);
  // R9: parallel data never selected without a valid rate
  a_r9_sel_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    txSelParallel |-> rateValid);
  // R3: status reads zero while invalid
  a_r3_status_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rateValid |-> (rateStatus == RATE_NONE));
endmodule

// File: rtl/rate_lock_seq.sv
module rate_lock_seq
  import rls_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              searchStart,
  input  logic              syncLost,
  input  logic              rateFound,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              txOverride,
  input  logic              manualGate,
  input  logic              rxClkFree,
  input  logic              txFifoRstWr,
  output logic              txFifoRst,
  output logic              rxFifoRst,
  output logic              txSelParallel,
  output logic              rxClkEn,
  output logic              rateValid,
  output logic [RATE_W-1:0] rateStatus,
  output logic              waitRecenter
);
  seqStrobe_t strobes;

  rls_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .searchStart(searchStart), .syncLost(syncLost), .rateFound(rateFound),
    .txOverride(txOverride), .manualGate(manualGate), .txFifoRstWr(txFifoRstWr),
    .strobes(strobes), .waitRecenter(waitRecenter)
  );

  rls_dpath #(.RATE_W(RATE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rateCode(rateCode),
    .rxClkFree(rxClkFree),
    .txFifoRst(txFifoRst), .rxFifoRst(rxFifoRst), .txSelParallel(txSelParallel),
    .rxClkEn(rxClkEn), .rateValid(rateValid), .rateStatus(rateStatus)
  );
endmodule

// File: tb/sim_rate_lock_seq.sv
module sim_rate_lock_seq;
  localparam int RW = 3;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic searchStart = 0, syncLost = 0, rateFound = 0;
  logic [RW-1:0] rateCode = '0;
  logic txOverride = 0, manualGate = 0, rxClkFree = 0, txFifoRstWr = 0;
  logic txFifoRst, rxFifoRst, txSelParallel, rxClkEn, rateValid, waitRecenter;
  logic [RW-1:0] rateStatus;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rate_lock_seq #(.RATE_W(RW)) u0 (
    .clk(clk), .rstN(rstN), .searchStart(searchStart), .syncLost(syncLost),
    .rateFound(rateFound), .rateCode(rateCode), .txOverride(txOverride),
    .manualGate(manualGate), .rxClkFree(rxClkFree), .txFifoRstWr(txFifoRstWr),
    .txFifoRst(txFifoRst), .rxFifoRst(rxFifoRst), .txSelParallel(txSelParallel),
    .rxClkEn(rxClkEn), .rateValid(rateValid), .rateStatus(rateStatus),
    .waitRecenter(waitRecenter)
  );

  // behavioural reference: 0 searching, 1 waiting for software, 2 running
  int mSt = 0;
  int mTx = 0, mRx = 0, mSel = 0, mClk = 0, mValid = 0, mCode = 0;

  always @(posedge clk) begin
    int wasSt;
    if (!rstN) begin
      mSt = 0; mTx = 0; mRx = 0; mSel = 0; mClk = 0; mValid = 0; mCode = 0;
    end else begin
      wasSt = mSt;
      mTx = txFifoRstWr ? 1 : 0;
      mRx = 0;
      if (searchStart || syncLost) begin
        mSt = 0; mSel = 0; mValid = 0; mCode = 0; mClk = rxClkFree ? 1 : 0;
      end else begin
        mSel = (wasSt == 2) ? 1 : 0;
        if (wasSt == 0) begin
          mClk = rxClkFree ? 1 : 0;
          if (rateFound) begin
            mTx = 1; mRx = 1; mValid = 1; mCode = int'(rateCode); mClk = 1;
            mSt = (txOverride && manualGate) ? 1 : 2;
          end
        end else if (wasSt == 1 && txFifoRstWr) begin
          mSt = 2;
        end
      end
    end
  end

  task automatic cmp(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      cmp("R2/R8 txFifoRst", int'(txFifoRst), mTx);
      cmp("R2 rxFifoRst", int'(rxFifoRst), mRx);
      cmp("R5/R6 txSelParallel", int'(txSelParallel), mSel);
      cmp("R7 rxClkEn", int'(rxClkEn), mClk);
      cmp("R3 rateValid", int'(rateValid), mValid);
      cmp("R3 rateStatus", int'(rateStatus), mCode);
      cmp("R6 waitRecenter", int'(waitRecenter), (mSt == 1) ? 1 : 0);
    end
    if (cycles > 5000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    searchStart = 0; syncLost = 0; rateFound = 0; txFifoRstWr = 0;
  endtask

  initial begin
    tick(3);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 txFifoRst", int'(txFifoRst), 0);
    cmp("R1 rxFifoRst", int'(rxFifoRst), 0);
    cmp("R1 txSelParallel", int'(txSelParallel), 0);
    cmp("R1 rateValid", int'(rateValid), 0);
    cmp("R1 waitRecenter", int'(waitRecenter), 0);
    tick(2);
    cmp("R7 clock held during search", int'(rxClkEn), 0);

    // ungated lock
    rateCode = 3'd5; rateFound = 1; tick();
    cmp("R2 tx pulse", int'(txFifoRst), 1);
    cmp("R2 rx pulse", int'(rxFifoRst), 1);
    cmp("R3 status", int'(rateStatus), 5);
    cmp("R7 clock released", int'(rxClkEn), 1);
    tick();
    cmp("R5 parallel selected", int'(txSelParallel), 1);
    cmp("R2 rx single", int'(rxFifoRst), 0);

    // R10: repeat success ignored
    rateCode = 3'd2; rateFound = 1; tick();
    cmp("R10 no rx pulse", int'(rxFifoRst), 0);
    cmp("R10 status kept", int'(rateStatus), 5);

    // R9 sync loss
    syncLost = 1; tick();
    cmp("R9 sel cleared", int'(txSelParallel), 0);
    cmp("R9 valid cleared", int'(rateValid), 0);

    // gated lock
    txOverride = 1; manualGate = 1; tick(2);
    rateCode = 3'd3; rateFound = 1; tick();
    cmp("R2 rx pulse gated", int'(rxFifoRst), 1);
    cmp("R7 clock not gated", int'(rxClkEn), 1);
    tick(4);
    cmp("R6 held", int'(txSelParallel), 0);
    cmp("R6 wait status", int'(waitRecenter), 1);
    cmp("R3 rate readable", int'(rateStatus), 3);
    rateFound = 1; tick();
    cmp("R10 ignored while held", int'(rxFifoRst), 0);
    txFifoRstWr = 1; tick();
    cmp("R6 recenter pulse", int'(txFifoRst), 1);
    cmp("R6 still off", int'(txSelParallel), 0);
    cmp("R6 wait cleared", int'(waitRecenter), 0);
    tick();
    cmp("R6 parallel after recenter", int'(txSelParallel), 1);

    // R4: gate alone without override
    searchStart = 1; tick();
    txOverride = 0; manualGate = 1;
    rateCode = 3'd1; rateFound = 1; tick(2);
    cmp("R4 gate ignored", int'(txSelParallel), 1);
    cmp("R4 no wait", int'(waitRecenter), 0);
    txFifoRstWr = 1; tick();
    cmp("R8 write while live", int'(txFifoRst), 1);

    // R8 write while searching
    searchStart = 1; tick();
    txFifoRstWr = 1; tick();
    cmp("R8 tx pulse in search", int'(txFifoRst), 1);
    cmp("R8 no rx pulse", int'(rxFifoRst), 0);
    tick();
    cmp("R8 no parallel", int'(txSelParallel), 0);

    // R9 priority over success; R7 free clock
    rxClkFree = 1; rateFound = 1; searchStart = 1; rateCode = 3'd6; tick();
    cmp("R9 no lock", int'(rateValid), 0);
    cmp("R9 no rx pulse", int'(rxFifoRst), 0);
    cmp("R7 free clock", int'(rxClkEn), 1);
    tick(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule